// File: doc/BRIEF.md
# Source-Select Fractional Clock-Enable Divider

This block turns one of several clock-enable strobe streams into a slower peripheral clock-enable stream. A control input gives a source index and an enable bit. A divide word holds a fixed-point divisor with an integer part and a fractional part. Every strobe on the selected source may or may not produce one output strobe. Over time the output rate equals the source rate times 2^FRAC_BITS divided by the divisor. A status bit follows the enable bit.

The divisor is read from a fixed place in the divide word. Its integer part always starts at bit 12, and its fractional bits sit directly below that bit. The widths of both parts are set per instance. An instance built with zero integer bits and zero fractional bits does not divide: it passes the selected source straight through. Fractional ratios come from a phase accumulator. The accumulator goes back to zero whenever the source index or the divisor changes.

Top module: `ckdiv_gen`

## Requirements
- R1: While `cfg_enable` is low, `clk_en_out` stays low whatever strobes arrive. After reset, `clk_en_out` and `busy` are both low.
- R2: `busy` equals the value `cfg_enable` had in the previous clock cycle.
- R3: `cfg_src` picks the source strobe `src_tick[cfg_src]`. Index 0 is ground and never produces output. Indices 1 to NUM_SRC-1 select that bit. Any index of NUM_SRC or above also acts as ground. Strobes on bits that are not selected have no effect.
- R4: The divisor is `div_word[12+INT_BITS-1 : 12-FRAC_BITS]`. The integer part starts at bit 12. Bits of `div_word` outside that field are ignored. With the defaults (INT_BITS=8, FRAC_BITS=4) the field is bits 19:8, so 2.5 is written as 0x2800.
- R5: With a divisor D ≥ 2^FRAC_BITS, after the accumulator is cleared, N selected strobes give exactly floor(N·2^FRAC_BITS / D) output strobes.
- R6: A divisor field of zero stops the output.
- R7: A nonzero divisor below 2^FRAC_BITS (a ratio below one) gives one output strobe for every selected source strobe.
- R8: A change of `cfg_src` or of the divisor field clears the accumulator. No output strobe is produced in the cycle where the change is seen.
- R9: An instance with INT_BITS=0 and FRAC_BITS=0 copies every selected strobe to the output while enabled, whatever `div_word` holds.
- R10: An output strobe appears one clock cycle after the source strobe that causes it, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | NUM_SRC | One clock-enable strobe per source; bit 0 is not used (ground) |
| cfg_enable | input | 1 | Output enable from the control word |
| cfg_src | input | SEL_W | Source index from the control word |
| div_word | input | WORD_W | Divide word that holds the fixed-point divisor field |
| clk_en_out | output | 1 | Divided peripheral clock-enable strobe |
| busy | output | 1 | Status: enable state seen in the previous cycle |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `src_tick` carries single-cycle strobes, and that the configuration inputs hold still between deliberate changes, so the accumulator bound and the restart checks see a stable divisor. The bench changes inputs only on the falling edge. After any change of source or divisor, it waits two idle cycles before it sends strobes, so the restart cycle never swallows a strobe the count expects. Ratio checks start from a cleared accumulator and end with idle cycles, so every strobe has time to reach the output.

// File: rtl/ckdiv_pkg.sv
// Package: constants and helpers shared by the clock-enable divider.
// Assumes FRAC_BITS never exceeds the field base.
package ckdiv_pkg;
    // Bit where the integer part of the divisor field begins.
    localparam int unsigned INT_FIELD_BASE = 12;

    // Gives a width of at least one bit for zero-width variants.
    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction
endpackage

// File: rtl/ckdiv_src_sel.sv
// Module: source strobe selector.
// Picks one strobe from the source vector by index. Index 0 and any index
// at or above NUM_SRC give ground (constant zero).
// Assumes the strobes are already synchronous to the block clock.
module ckdiv_src_sel #(
    parameter int unsigned NUM_SRC = 10,
    parameter int unsigned SEL_W   = 4
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               sel_tick
);
    // Purpose: one-hot compare of the index against every source slot.
    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) begin
                sel_tick = (i == 0) ? 1'b0 : src_tick[i];
            end
        end
    end
endmodule

// File: rtl/ckdiv_cfg_track.sv
// Module: divisor field extraction and change detection.
// Pulls the fixed-point divisor out of the divide word, flags a zero
// divisor, and raises restart for one cycle whenever the source index or
// the divisor differs from the values seen in the previous cycle.
// Assumes configuration inputs are synchronous to clk.
module ckdiv_cfg_track #(
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned DVW       = 12,
    parameter int unsigned FIELD_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cfg_src,
    input  logic [WORD_W-1:0] div_word,
    output logic [DVW-1:0]    div_val,
    output logic              div_zero,
    output logic              restart
);
    logic [SEL_W-1:0] prev_src;
    logic [DVW-1:0]   prev_div;

    // Purpose: shift the field down to bit 0 and drop everything above it.
    always_comb begin
        div_val  = DVW'(div_word >> FIELD_LSB);
        div_zero = (div_val == '0);
        restart  = (cfg_src != prev_src) || (div_val != prev_div);
    end

    // Purpose: remember last cycle's configuration for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_src <= '0;
            prev_div <= '0;
        end else begin
            prev_src <= cfg_src;
            prev_div <= div_val;
        end
    end
endmodule

// File: rtl/ckdiv_phase_acc.sv
// Module: fractional phase accumulator.
// Each selected strobe adds 2^FRAC_BITS. When the sum reaches the divisor,
// one output strobe is registered and the divisor is subtracted. A divisor
// below 2^FRAC_BITS gives one output per strobe with the phase held at zero.
// Disable, a zero divisor or a restart clears the phase and blocks output.
// Assumes ACC_W = DVW + 1, so the sum cannot overflow.
module ckdiv_phase_acc #(
    parameter int unsigned DVW       = 12,
    parameter int unsigned ACC_W     = 13,
    parameter int unsigned FRAC_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             restart,
    input  logic             div_zero,
    input  logic [DVW-1:0]   div_val,
    output logic             pulse,
    output logic [ACC_W-1:0] acc_q
);
    localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_BITS;

    logic [ACC_W-1:0] div_ext;
    logic [ACC_W-1:0] sum;
    logic             below_unity;
    logic             reach;

    // Purpose: next phase and threshold compare.
    always_comb begin
        div_ext     = {1'b0, div_val};
        sum         = acc_q + STEP;
        below_unity = (div_ext < STEP);
        reach       = (sum >= div_ext);
    end

    // Purpose: update the phase and register the output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            pulse <= 1'b0;
        end else if (!enable || div_zero || restart) begin
            acc_q <= '0;
            pulse <= 1'b0;
        end else if (tick) begin
            if (below_unity) begin
                acc_q <= '0;
                pulse <= 1'b1;
            end else if (reach) begin
                acc_q <= sum - div_ext;
                pulse <= 1'b1;
            end else begin
                acc_q <= sum;
                pulse <= 1'b0;
            end
        end else begin
            pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/ckdiv_gen.sv
// Module: source-select fractional clock-enable divider (top).
// Selects a source strobe, divides it by the fixed-point field of div_word
// (integer part from bit 12 upward, FRAC_BITS fraction bits below), and
// registers the result on clk_en_out. With INT_BITS and FRAC_BITS both
// zero the divider is left out and the selected strobe passes through.
// Assumes FRAC_BITS <= 12 and 12 + INT_BITS <= WORD_W.
module ckdiv_gen
    import ckdiv_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 10,
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned INT_BITS  = 8,
    parameter int unsigned FRAC_BITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               cfg_enable,
    input  logic [SEL_W-1:0]   cfg_src,
    input  logic [WORD_W-1:0]  div_word,
    output logic               clk_en_out,
    output logic               busy
);
    localparam int unsigned DIV_BITS  = INT_BITS + FRAC_BITS;
    localparam int unsigned DVW       = at_least_one(DIV_BITS);
    localparam int unsigned ACC_W     = DVW + 1;
    localparam int unsigned FIELD_LSB = INT_FIELD_BASE - FRAC_BITS;

    logic             sel_tick;
    logic [DVW-1:0]   div_val;
    logic             div_zero;
    logic             restart;
    logic [ACC_W-1:0] acc_view;

    ckdiv_src_sel #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W)
    ) u_sel (
        .src_tick (src_tick),
        .sel      (cfg_src),
        .sel_tick (sel_tick)
    );

    ckdiv_cfg_track #(
        .SEL_W     (SEL_W),
        .WORD_W    (WORD_W),
        .DVW       (DVW),
        .FIELD_LSB (FIELD_LSB)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_src  (cfg_src),
        .div_word (div_word),
        .div_val  (div_val),
        .div_zero (div_zero),
        .restart  (restart)
    );

    generate
        if (DIV_BITS == 0) begin : g_pass
            // Purpose: pass-through engine, one output per selected strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    clk_en_out <= 1'b0;
                end else begin
                    clk_en_out <= cfg_enable && sel_tick;
                end
            end
            assign acc_view = '0;
        end else begin : g_div
            ckdiv_phase_acc #(
                .DVW       (DVW),
                .ACC_W     (ACC_W),
                .FRAC_BITS (FRAC_BITS)
            ) u_acc (
                .clk      (clk),
                .rst_n    (rst_n),
                .enable   (cfg_enable),
                .tick     (sel_tick),
                .restart  (restart),
                .div_zero (div_zero),
                .div_val  (div_val),
                .pulse    (clk_en_out),
                .acc_q    (acc_view)
            );
        end
    endgenerate

    // Purpose: status bit that follows the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else begin
            busy <= cfg_enable;
        end
    end
endmodule

// File: rtl/ckdiv_gen_chk.sv
// Module: assertion checker for ckdiv_gen, bound to every instance.
// Assumes synchronous single-cycle source strobes.
module ckdiv_gen_chk #(
    parameter int unsigned NUM_SRC   = 10,
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned DIV_BITS  = 12,
    parameter int unsigned DVW       = 12,
    parameter int unsigned ACC_W     = 13,
    parameter int unsigned FRAC_BITS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic [SEL_W-1:0] cfg_src,
    input logic             sel_tick,
    input logic [DVW-1:0]   div_val,
    input logic             div_zero,
    input logic             restart,
    input logic [ACC_W-1:0] acc_view,
    input logic             clk_en_out,
    input logic             busy
);
    localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_BITS;
    localparam bit DIVIDES = (DIV_BITS != 0);

    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !clk_en_out);

    p_busy_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable |=> busy);

    p_busy_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !busy);

    p_ground_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src == '0 || cfg_src >= SEL_W'(NUM_SRC)) |-> !sel_tick);

    p_acc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (DIVIDES && !restart && !div_zero) |-> (acc_view < {1'b0, div_val}));

    p_zero_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (DIVIDES && div_zero) |=> !clk_en_out);

    p_below_unity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (DIVIDES && cfg_enable && !div_zero && !restart && sel_tick
         && ({1'b0, div_val} < STEP)) |=> clk_en_out);

    p_restart_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (DIVIDES && restart) |=> (!clk_en_out && acc_view == '0));

    p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_out |-> $past(sel_tick));
endmodule

bind ckdiv_gen ckdiv_gen_chk #(
    .NUM_SRC   (NUM_SRC),
    .SEL_W     (SEL_W),
    .DIV_BITS  (DIV_BITS),
    .DVW       (DVW),
    .ACC_W     (ACC_W),
    .FRAC_BITS (FRAC_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_src    (cfg_src),
    .sel_tick   (sel_tick),
    .div_val    (div_val),
    .div_zero   (div_zero),
    .restart    (restart),
    .acc_view   (acc_view),
    .clk_en_out (clk_en_out),
    .busy       (busy)
);

// File: tb/tb_ckdiv_gen.sv
// Bench: directed tests for the clock-enable divider and a pass-through instance.
module tb_ckdiv_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_SRC    = 10;
    localparam int SEL_W      = 4;
    localparam int WORD_W     = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] src_tick = '0;
    logic               cfg_enable = 1'b0;
    logic [SEL_W-1:0]   cfg_src = '0;
    logic [WORD_W-1:0]  div_word = '0;
    logic               clk_en_out;
    logic               busy;

    logic [NUM_SRC-1:0] pt_tick = '0;
    logic               pt_enable = 1'b0;
    logic [SEL_W-1:0]   pt_src = '0;
    logic [WORD_W-1:0]  pt_div = '0;
    logic               pt_out;
    logic               pt_busy;

    int total = 0;
    int bad   = 0;
    int cnt    = 0;
    int pt_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ckdiv_gen #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .WORD_W(WORD_W),
                .INT_BITS(8), .FRAC_BITS(4)) dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_enable(cfg_enable),
        .cfg_src(cfg_src), .div_word(div_word), .clk_en_out(clk_en_out), .busy(busy));

    ckdiv_gen #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .WORD_W(WORD_W),
                .INT_BITS(0), .FRAC_BITS(0)) dut_pt (
        .clk(clk), .rst_n(rst_n), .src_tick(pt_tick), .cfg_enable(pt_enable),
        .cfg_src(pt_src), .div_word(pt_div), .clk_en_out(pt_out), .busy(pt_busy));

    // Output strobe counters, sampled on the falling edge.
    always @(negedge clk) begin
        if (clk_en_out) cnt = cnt + 1;
        if (pt_out) pt_cnt = pt_cnt + 1;
    end

    task automatic chk(input int act, input int exp, input string tag);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply a configuration, let the restart pass, clear the counter.
    task automatic configure(input logic en, input logic [SEL_W-1:0] s,
                             input logic [WORD_W-1:0] w);
        @(negedge clk);
        cfg_enable = en; cfg_src = s; div_word = w;
        repeat (2) @(negedge clk);
        #1 cnt = 0;
    endtask

    // Drive n consecutive strobes with the given mask, then idle two cycles.
    task automatic strobes(input logic [NUM_SRC-1:0] mask, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            src_tick = mask;
        end
        @(negedge clk);
        src_tick = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(int'(clk_en_out), 0, "R1 output low after reset");
        chk(int'(busy), 0, "R2 busy low after reset");
    endtask

    task automatic t_busy();
        @(negedge clk);
        cfg_enable = 1'b1;
        #1 chk(int'(busy), 0, "R2 busy before enable edge");
        @(negedge clk);
        chk(int'(busy), 1, "R2 busy follows enable");
        cfg_enable = 1'b0;
        @(negedge clk);
        chk(int'(busy), 0, "R2 busy follows disable");
    endtask

    task automatic t_disabled();
        configure(1'b0, 4'd1, 32'h0000_1000);
        strobes(10'b00_0000_0010, 20);
        chk(cnt, 0, "R1 disabled gives no output");
    endtask

    task automatic t_ground();
        configure(1'b1, 4'd0, 32'h0000_1000);
        strobes('1, 12);
        chk(cnt, 0, "R3 index 0 is ground");
        configure(1'b1, 4'd12, 32'h0000_1000);
        strobes('1, 12);
        chk(cnt, 0, "R3 index beyond sources is ground");
    endtask

    task automatic t_select();
        configure(1'b1, 4'd4, 32'h0000_1000);
        strobes(10'b00_0010_0000, 10);
        chk(cnt, 0, "R3 unselected source ignored");
        configure(1'b1, 4'd5, 32'h0000_1000);
        strobes(10'b00_0010_0000, 10);
        chk(cnt, 10, "R3 selected source at ratio one");
    endtask

    task automatic t_ratio();
        configure(1'b1, 4'd1, 32'h0000_3000);
        strobes(10'b00_0000_0010, 300);
        chk(cnt, 100, "R5 integer divide by 3");
        configure(1'b1, 4'd1, 32'hABC0_28FF);
        strobes(10'b00_0000_0010, 100);
        chk(cnt, 40, "R4 divide 2.5 with bits outside field set");
        configure(1'b1, 4'd9, 32'h0000_1400);
        strobes(10'b10_0000_0000, 50);
        chk(cnt, 40, "R5 divide 1.25 on source 9");
    endtask

    task automatic t_zero();
        configure(1'b1, 4'd1, 32'hFFF0_00FF);
        strobes(10'b00_0000_0010, 30);
        chk(cnt, 0, "R6 zero divisor stops output");
    endtask

    task automatic t_below();
        configure(1'b1, 4'd2, 32'h0000_0800);
        strobes(10'b00_0000_0100, 25);
        chk(cnt, 25, "R7 divisor 0.5 gives one per strobe");
    endtask

    task automatic t_restart();
        configure(1'b1, 4'd1, 32'h0000_3000);
        strobes(10'b00_0000_0010, 2);
        chk(cnt, 0, "R8 no output after two strobes at divide 3");
        configure(1'b1, 4'd1, 32'h0000_4000);
        strobes(10'b00_0000_0010, 3);
        chk(cnt, 0, "R8 divisor change clears phase");
        strobes(10'b00_0000_0010, 1);
        chk(cnt, 1, "R8 first output on fourth strobe at divide 4");
        configure(1'b1, 4'd1, 32'h0000_3000);
        strobes(10'b00_0000_0010, 2);
        configure(1'b1, 4'd2, 32'h0000_3000);
        strobes(10'b00_0000_0100, 2);
        chk(cnt, 0, "R8 source change clears phase");
    endtask

    task automatic t_latency();
        configure(1'b1, 4'd3, 32'h0000_1000);
        @(negedge clk);
        src_tick = 10'b00_0000_1000;
        #1 chk(int'(clk_en_out), 0, "R10 no output in strobe cycle");
        @(negedge clk);
        src_tick = '0;
        chk(int'(clk_en_out), 1, "R10 output one cycle after strobe");
        @(negedge clk);
        chk(int'(clk_en_out), 0, "R10 output lasts one cycle");
    endtask

    task automatic t_pass();
        @(negedge clk);
        pt_enable = 1'b1; pt_src = 4'd3; pt_div = '0;
        repeat (2) @(negedge clk);
        #1 pt_cnt = 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            pt_tick = 10'b00_0000_1000;
        end
        @(negedge clk);
        pt_tick = '0;
        repeat (2) @(negedge clk);
        chk(pt_cnt, 15, "R9 pass-through copies every strobe");
        chk(int'(pt_busy), 1, "R9 pass-through busy while enabled");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_busy();
        t_disabled();
        t_ground();
        t_select();
        t_ratio();
        t_zero();
        t_below();
        t_restart();
        t_latency();
        t_pass();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule